// File: doc/BRIEF.md
# Accumulator Register-Operation and Peripheral Interrupt Unit

This block executes the opcode-7 group of a 16-bit accumulator machine. With the indirect bit clear, the low twelve instruction bits select one operation on the accumulator and its carry extension bit. These operations are clears, complements, rotates through the extension bit, an increment, four conditional skips and a halt. With the indirect bit set, the same twelve bits select peripheral operations: move an input character into the accumulator, send an output character, skip on either peripheral flag, and switch interrupts on or off. Each operation completes on the execute strobe and clears the sequence counter.

The unit owns the accumulator, the extension bit, the program counter, the interrupt enable and the interrupt request. Characters arrive and leave on valid/ready streams. An input character is taken only while the one-character input register is empty (`in_ready` high). The output register shows a character on `out_valid`, holds it stable until `out_ready`, and only then counts as accepted. When the request is pending and the control sequencer starts a fetch, the unit runs a three-cycle interrupt cycle in its place. The cycle saves the return address to memory word 0, then sets the program counter to 1 and disables interrupts.

Top module: `rrio_unit`

## Requirements
- R1: After reset the accumulator, extension bit and program counter are 0, `halt_req` and `irq_active` are low, `in_ready` is high (input register empty), `out_valid` is low (output register empty) and interrupts are disabled.
- R2: An execute strobe with `ir_word[14:12]=111` and `ind_bit=0` does the following: bit 11 clears the accumulator, bit 10 clears the extension bit, bit 9 complements the accumulator and bit 8 complements the extension bit.
- R3: In the same group, bit 7 rotates right through the extension bit (the accumulator's bit 0 goes to the extension bit and the old extension bit goes to bit 15). Bit 6 rotates left, the mirror of this.
- R4: In the same group, bit 5 increments the accumulator modulo 2^16 and leaves the extension bit unchanged.
- R5: In the same group, bits 4, 3, 2 and 1 add 1 to the program counter when, respectively, the accumulator's bit 15 is 0, bit 15 is 1, the accumulator is zero, or the extension bit is 0. Otherwise the counter is unchanged.
- R6: In the same group, bit 0 raises `halt_req`, which stays high until reset.
- R7: An execute strobe whose `ir_word[14:12]` is not 111 changes nothing. `sc_clr` is high in the cycle of each opcode-7 execute and low for other words.
- R8: A character is captured when `in_valid` and `in_ready` are both high, and `in_ready` then stays low. With `ind_bit=1`, bit 11 copies the held character into accumulator bits 7:0, keeps bits 15:8, and empties the input register.
- R9: With `ind_bit=1`, bit 10 loads accumulator bits 7:0 into the output register and raises `out_valid` only when the register is empty. If the register is still occupied the operation is ignored. `out_valid` and `out_data` hold until `out_ready`.
- R10: With `ind_bit=1`, bit 9 skips when the input register is full, and bit 8 skips when the output register is empty.
- R11: With `ind_bit=1`, bit 7 enables interrupts and bit 6 disables them. The request sets only when interrupts are enabled, a character is held or the output register is empty, and `fetch_phase` is low.
- R12: A `fetch_req` while the request is set starts the interrupt cycle. In the second cycle `mem_wr` writes the program counter value at start to address 0 and the counter becomes 0. In the third cycle `sc_clr` is high, and the counter then becomes 1 with interrupts disabled and the request cleared. With no request, `fetch_req` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_t3 | input | 1 | Execute-step strobe |
| ir_word | input | 16 | Current instruction word |
| ind_bit | input | 1 | Indirect bit; 1 selects the peripheral group |
| fetch_phase | input | 1 | High during fetch steps |
| fetch_req | input | 1 | Start-of-fetch pulse |
| ac_load | input | 1 | Load the accumulator from `ac_din` |
| ac_din | input | 16 | Accumulator load value |
| pc_inc | input | 1 | Increment the program counter |
| pc_load | input | 1 | Load the program counter from `pc_din` |
| pc_din | input | 12 | Program counter load value |
| in_valid | input | 1 | Input character valid |
| in_data | input | 8 | Input character |
| in_ready | output | 1 | Input register empty |
| out_valid | output | 1 | Output character valid |
| out_data | output | 8 | Output character |
| out_ready | input | 1 | Peripheral accepts the output character |
| ac_q | output | 16 | Accumulator |
| e_q | output | 1 | Extension bit |
| pc_q | output | 12 | Program counter |
| halt_req | output | 1 | Halt request |
| sc_clr | output | 1 | Clear the sequence counter |
| irq_active | output | 1 | Interrupt cycle running |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory write address |
| mem_data | output | 16 | Memory write data |

## Verification
The checker assumes that an opcode-7 execute word has at most one of its low twelve bits set. It also assumes that the execute strobe, program-counter loads and fetch pulses never coincide with one another. The stimulus issues each operation as its own one-hot word in a separate cycle and keeps `fetch_phase` high around `fetch_req`, as a real sequencer would. Peripheral handshakes are driven only between operations, so a capture or acceptance never lands in the same cycle as the operation that reads the same flag.

// File: rtl/rrio_pkg.sv
package rrio_pkg;
  // Operation ranks: rank k selects instruction bit (field width - 1 - k).
  localparam int RR_CLR_AC  = 0;
  localparam int RR_CLR_E   = 1;
  localparam int RR_CMP_AC  = 2;
  localparam int RR_CMP_E   = 3;
  localparam int RR_ROT_R   = 4;
  localparam int RR_ROT_L   = 5;
  localparam int RR_INC_AC  = 6;
  localparam int RR_SK_POS  = 7;
  localparam int RR_SK_NEG  = 8;
  localparam int RR_SK_ZAC  = 9;
  localparam int RR_SK_ZE   = 10;
  localparam int RR_HALT    = 11;

  localparam int IO_TAKE    = 0;
  localparam int IO_SEND    = 1;
  localparam int IO_SK_IN   = 2;
  localparam int IO_SK_OUT  = 3;
  localparam int IO_IRQ_ON  = 4;
  localparam int IO_IRQ_OFF = 5;

  localparam logic [2:0] OPC_GROUP7 = 3'b111;

  typedef enum logic [1:0] {IC_SAVE = 2'd0, IC_WRITE = 2'd1, IC_DONE = 2'd2} ic_step_t;
endpackage

// File: rtl/rrio_regops.sv
module rrio_regops
  import rrio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] ac,
  input  logic              e,
  input  logic [DATA_W-5:0] sel,
  output logic [DATA_W-1:0] ac_nx,
  output logic              e_nx,
  output logic              skip,
  output logic              halt
);
  localparam int OPF_W = DATA_W - 4;

  logic rot_bit;

  function automatic int pos(input int rank);
    return OPF_W - 1 - rank;
  endfunction

  always_comb begin
    ac_nx   = ac;
    e_nx    = e;
    rot_bit = 1'b0;
    if (sel[pos(RR_CLR_AC)]) ac_nx = '0;
    if (sel[pos(RR_CLR_E)])  e_nx  = 1'b0;
    if (sel[pos(RR_CMP_AC)]) ac_nx = ~ac_nx;
    if (sel[pos(RR_CMP_E)])  e_nx  = ~e_nx;
    if (sel[pos(RR_ROT_R)]) begin
      rot_bit = ac_nx[0];
      ac_nx   = {e_nx, ac_nx[DATA_W-1:1]};
      e_nx    = rot_bit;
    end
    if (sel[pos(RR_ROT_L)]) begin
      rot_bit = ac_nx[DATA_W-1];
      ac_nx   = {ac_nx[DATA_W-2:0], e_nx};
      e_nx    = rot_bit;
    end
    if (sel[pos(RR_INC_AC)]) ac_nx = ac_nx + 1'b1;
  end

  assign skip = (sel[pos(RR_SK_POS)] & ~ac[DATA_W-1])
              | (sel[pos(RR_SK_NEG)] &  ac[DATA_W-1])
              | (sel[pos(RR_SK_ZAC)] & (ac == '0))
              | (sel[pos(RR_SK_ZE)]  & ~e);
  assign halt = sel[pos(RR_HALT)];
endmodule

// File: rtl/rrio_io.sv
module rrio_io #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic [CHAR_W-1:0] in_char,
  output logic              in_full,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_empty,
  input  logic              do_take,
  input  logic              do_send,
  input  logic [CHAR_W-1:0] send_src
);
  logic capture;

  assign in_ready  = ~in_full;
  assign capture   = in_valid & ~in_full;
  assign out_valid = ~out_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_full   <= 1'b0;
      in_char   <= '0;
      out_empty <= 1'b1;
      out_data  <= '0;
    end else begin
      in_full <= (in_full & ~do_take) | capture;
      if (capture) in_char <= in_data;
      if (do_send && out_empty) begin
        out_data  <= send_src;
        out_empty <= 1'b0;
      end else if (!out_empty && out_ready) begin
        out_empty <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rrio_irq.sv
module rrio_irq
  import rrio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_set,
  input  logic en_clr,
  input  logic flag_any,
  input  logic fetch_phase,
  input  logic fetch_req,
  output logic irq_en,
  output logic irq_pend,
  output logic busy,
  output logic st_save,
  output logic st_write,
  output logic st_done
);
  ic_step_t step;

  assign st_save  = busy && (step == IC_SAVE);
  assign st_write = busy && (step == IC_WRITE);
  assign st_done  = busy && (step == IC_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en   <= 1'b0;
      irq_pend <= 1'b0;
      busy     <= 1'b0;
      step     <= IC_SAVE;
    end else if (st_done) begin
      irq_en   <= 1'b0;
      irq_pend <= 1'b0;
      busy     <= 1'b0;
      step     <= IC_SAVE;
    end else begin
      if (en_clr)      irq_en <= 1'b0;
      else if (en_set) irq_en <= 1'b1;
      if (!busy && !fetch_phase && irq_en && flag_any) irq_pend <= 1'b1;
      if (!busy && fetch_req && irq_pend) begin
        busy <= 1'b1;
        step <= IC_SAVE;
      end else if (busy) begin
        step <= (step == IC_SAVE) ? IC_WRITE : IC_DONE;
      end
    end
  end
endmodule

// File: rtl/rrio_unit.sv
module rrio_unit
  import rrio_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CHAR_W     = 8,
  parameter int ADDR_W     = 12,
  parameter int SAVE_ADDR  = 0,
  parameter int ENTRY_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_t3,
  input  logic [DATA_W-1:0] ir_word,
  input  logic              ind_bit,
  input  logic              fetch_phase,
  input  logic              fetch_req,
  input  logic              ac_load,
  input  logic [DATA_W-1:0] ac_din,
  input  logic              pc_inc,
  input  logic              pc_load,
  input  logic [ADDR_W-1:0] pc_din,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  input  logic              out_ready,
  output logic [DATA_W-1:0] ac_q,
  output logic              e_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic              halt_req,
  output logic              sc_clr,
  output logic              irq_active,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  localparam int OPF_W = DATA_W - 4;

  logic [OPF_W-1:0]  sel;
  logic              is_op7, rr_go, io_go;
  logic [DATA_W-1:0] rr_ac;
  logic              rr_e, rr_skip, rr_halt;
  logic              do_take, do_send, io_skip, skip_any;
  logic [CHAR_W-1:0] in_char;
  logic              in_full, out_empty;
  logic              irq_en, irq_pend, irq_busy, st_save, st_write, st_done;
  logic [DATA_W-1:0] ac_r;
  logic              e_r, halted;
  logic [ADDR_W-1:0] pc_r, tr_r;

  function automatic int pos(input int rank);
    return OPF_W - 1 - rank;
  endfunction

  assign sel    = ir_word[OPF_W-1:0];
  assign is_op7 = exec_t3 && (ir_word[DATA_W-2 -: 3] == OPC_GROUP7) && !irq_busy;
  assign rr_go  = is_op7 & ~ind_bit;
  assign io_go  = is_op7 &  ind_bit;

  rrio_regops #(.DATA_W(DATA_W)) u_regops (
    .ac(ac_r), .e(e_r), .sel(sel),
    .ac_nx(rr_ac), .e_nx(rr_e), .skip(rr_skip), .halt(rr_halt)
  );

  assign do_take = io_go & sel[pos(IO_TAKE)];
  assign do_send = io_go & sel[pos(IO_SEND)];
  assign io_skip = io_go & ((sel[pos(IO_SK_IN)] & in_full) | (sel[pos(IO_SK_OUT)] & out_empty));
  assign skip_any = (rr_go & rr_skip) | io_skip;

  rrio_io #(.CHAR_W(CHAR_W)) u_io (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .in_char(in_char), .in_full(in_full),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_empty(out_empty),
    .do_take(do_take), .do_send(do_send), .send_src(ac_r[CHAR_W-1:0])
  );

  rrio_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .en_set(io_go & sel[pos(IO_IRQ_ON)]),
    .en_clr(io_go & sel[pos(IO_IRQ_OFF)]),
    .flag_any(in_full | out_empty),
    .fetch_phase(fetch_phase), .fetch_req(fetch_req),
    .irq_en(irq_en), .irq_pend(irq_pend), .busy(irq_busy),
    .st_save(st_save), .st_write(st_write), .st_done(st_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_r   <= '0;
      e_r    <= 1'b0;
      pc_r   <= '0;
      tr_r   <= '0;
      halted <= 1'b0;
    end else begin
      if (rr_go) begin
        ac_r <= rr_ac;
        e_r  <= rr_e;
      end else if (do_take) begin
        ac_r <= {ac_r[DATA_W-1:CHAR_W], in_char};
      end else if (ac_load) begin
        ac_r <= ac_din;
      end
      if (rr_go && rr_halt) halted <= 1'b1;
      if (st_save) tr_r <= pc_r;
      if (st_write)      pc_r <= ADDR_W'(SAVE_ADDR);
      else if (st_done)  pc_r <= ADDR_W'(ENTRY_ADDR);
      else if (skip_any) pc_r <= pc_r + 1'b1;
      else if (pc_load)  pc_r <= pc_din;
      else if (pc_inc)   pc_r <= pc_r + 1'b1;
    end
  end

  assign ac_q       = ac_r;
  assign e_q        = e_r;
  assign pc_q       = pc_r;
  assign halt_req   = halted;
  assign sc_clr     = is_op7 | st_done;
  assign irq_active = irq_busy;
  assign mem_wr     = st_write;
  assign mem_addr   = ADDR_W'(SAVE_ADDR);
  assign mem_data   = {{(DATA_W-ADDR_W){1'b0}}, tr_r};
endmodule

// File: rtl/rrio_chk.sv
module rrio_chk #(
  parameter int DATA_W     = 16,
  parameter int CHAR_W     = 8,
  parameter int ADDR_W     = 12,
  parameter int SAVE_ADDR  = 0,
  parameter int ENTRY_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exec_t3,
  input logic [DATA_W-1:0] ir_word,
  input logic              fetch_phase,
  input logic              irq_pend,
  input logic              irq_en,
  input logic              irq_active,
  input logic              sc_clr,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] pc_q,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CHAR_W-1:0] out_data,
  input logic              halt_req
);
  // R7
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_t3 && ir_word[DATA_W-2 -: 3] == 3'b111) |-> $onehot0(ir_word[DATA_W-5:0]));

  // R6
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> halt_req);

  // R8
  in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R11
  pend_outside_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> !$past(fetch_phase));

  // R12
  save_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (irq_active && mem_addr == ADDR_W'(SAVE_ADDR)));

  // R12
  entry_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_active && sc_clr) |=> (pc_q == ADDR_W'(ENTRY_ADDR) && !irq_en && !irq_active));
endmodule

bind rrio_unit rrio_chk #(
  .DATA_W(DATA_W), .CHAR_W(CHAR_W), .ADDR_W(ADDR_W),
  .SAVE_ADDR(SAVE_ADDR), .ENTRY_ADDR(ENTRY_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .exec_t3(exec_t3), .ir_word(ir_word),
  .fetch_phase(fetch_phase), .irq_pend(irq_pend), .irq_en(irq_en),
  .irq_active(irq_active), .sc_clr(sc_clr), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .pc_q(pc_q), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .halt_req(halt_req)
);

// File: tb/rrio_unit_tb_top.sv
module rrio_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_t3 = 1'b0;
  logic [15:0] ir_word = '0;
  logic        ind_bit = 1'b0;
  logic        fetch_phase = 1'b0;
  logic        fetch_req = 1'b0;
  logic        ac_load = 1'b0;
  logic [15:0] ac_din = '0;
  logic        pc_inc = 1'b0;
  logic        pc_load = 1'b0;
  logic [11:0] pc_din = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic [15:0] ac_q;
  logic        e_q;
  logic [11:0] pc_q;
  logic        halt_req, sc_clr, irq_active, mem_wr;
  logic [11:0] mem_addr;
  logic [15:0] mem_data;

  always #10 clk = ~clk;

  rrio_unit dut_i (
    .clk(clk), .rst_n(rst_n), .exec_t3(exec_t3), .ir_word(ir_word), .ind_bit(ind_bit),
    .fetch_phase(fetch_phase), .fetch_req(fetch_req), .ac_load(ac_load), .ac_din(ac_din),
    .pc_inc(pc_inc), .pc_load(pc_load), .pc_din(pc_din), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .ac_q(ac_q), .e_q(e_q), .pc_q(pc_q), .halt_req(halt_req),
    .sc_clr(sc_clr), .irq_active(irq_active), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_data(mem_data)
  );

  typedef struct {
    string       req;
    logic [15:0] ac;
    logic        e;
    logic [11:0] pc;
    logic        halt;
    logic        in_rdy;
    logic        out_vld;
    logic [7:0]  out_d;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fails  = 0;

  // reference state
  logic [15:0] m_ac = '0;
  logic        m_e = 1'b0;
  logic [11:0] m_pc = '0;
  logic        m_halt = 1'b0, m_in_full = 1'b0, m_out_busy = 1'b0;
  logic [7:0]  m_in_char = '0, m_out_d = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input string req);
    exp_t x;
    x.req = req; x.ac = m_ac; x.e = m_e; x.pc = m_pc; x.halt = m_halt;
    x.in_rdy = !m_in_full; x.out_vld = m_out_busy; x.out_d = m_out_d;
    q.push_back(x);
  endtask

  // monitor: compares registered outputs half a cycle after each edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      check(ac_q == x.ac, x.req, "ac", 32'(ac_q), 32'(x.ac));
      check(e_q == x.e, x.req, "e", 32'(e_q), 32'(x.e));
      check(pc_q == x.pc, x.req, "pc", 32'(pc_q), 32'(x.pc));
      check(halt_req == x.halt, x.req, "halt", 32'(halt_req), 32'(x.halt));
      check(in_ready == x.in_rdy, x.req, "in_ready", 32'(in_ready), 32'(x.in_rdy));
      check(out_valid == x.out_vld, x.req, "out_valid", 32'(out_valid), 32'(x.out_vld));
      check(out_data == x.out_d, x.req, "out_data", 32'(out_data), 32'(x.out_d));
    end
  end

  // driver: called at a negedge, returns at the next negedge
  task automatic op(input logic [15:0] w, input logic ib, input string req);
    logic [11:0] s;
    logic        op7, sk, t;
    s   = w[11:0];
    op7 = (w[14:12] == 3'b111);
    sk  = 1'b0;
    exec_t3 = 1'b1; ir_word = w; ind_bit = ib;
    #1 check(sc_clr == op7, "R7", "sc_clr", 32'(sc_clr), 32'(op7));
    if (op7 && !ib) begin
      sk = (s[4] && !m_ac[15]) || (s[3] && m_ac[15]) || (s[2] && m_ac == 0) || (s[1] && !m_e);
      if (s[11]) m_ac = '0;
      if (s[10]) m_e = 1'b0;
      if (s[9])  m_ac = ~m_ac;
      if (s[8])  m_e = ~m_e;
      if (s[7]) begin t = m_ac[0]; m_ac = {m_e, m_ac[15:1]}; m_e = t; end
      if (s[6]) begin t = m_ac[15]; m_ac = {m_ac[14:0], m_e}; m_e = t; end
      if (s[5])  m_ac = m_ac + 16'd1;
      if (s[0])  m_halt = 1'b1;
    end else if (op7 && ib) begin
      sk = (s[9] && m_in_full) || (s[8] && !m_out_busy);
      if (s[11]) begin m_ac[7:0] = m_in_char; m_in_full = 1'b0; end
      if (s[10] && !m_out_busy) begin m_out_d = m_ac[7:0]; m_out_busy = 1'b1; end
    end
    if (sk) m_pc = m_pc + 12'd1;
    @(posedge clk); push(req);
    @(negedge clk); exec_t3 = 1'b0; ir_word = '0; ind_bit = 1'b0;
  endtask

  task automatic load_ac(input logic [15:0] v);
    ac_load = 1'b1; ac_din = v; m_ac = v;
    @(posedge clk); push("R2");
    @(negedge clk); ac_load = 1'b0;
  endtask

  task automatic load_pc(input logic [11:0] v);
    pc_load = 1'b1; pc_din = v; m_pc = v;
    @(posedge clk); push("R12");
    @(negedge clk); pc_load = 1'b0;
  endtask

  task automatic give_char(input logic [7:0] c);
    in_valid = 1'b1; in_data = c;
    if (!m_in_full) begin m_in_full = 1'b1; m_in_char = c; end
    @(posedge clk); push("R8");
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic take_out();
    out_ready = 1'b1; m_out_busy = 1'b0;
    @(posedge clk); push("R9");
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    push("R1");
    idle(1);

    // R2 R3 R4 R5 register group
    load_ac(16'h8001);
    op(16'h7080, 1'b0, "R3");   // rotate right
    op(16'h7040, 1'b0, "R3");   // rotate left
    op(16'h7100, 1'b0, "R2");   // complement E
    op(16'h7200, 1'b0, "R2");   // complement AC
    op(16'h7010, 1'b0, "R5");   // skip if positive (taken)
    op(16'h7008, 1'b0, "R5");   // skip if negative (not taken)
    op(16'h7020, 1'b0, "R4");   // increment
    op(16'h7800, 1'b0, "R2");   // clear AC
    op(16'h7004, 1'b0, "R5");   // skip if AC zero (taken)
    op(16'h7002, 1'b0, "R5");   // skip if E zero (not taken)
    op(16'h7400, 1'b0, "R2");   // clear E
    op(16'h7002, 1'b0, "R5");   // skip if E zero (taken)
    load_ac(16'hFFFF);
    op(16'h7100, 1'b0, "R2");
    op(16'h7020, 1'b0, "R4");   // wraps to 0, E stays 1
    op(16'h7080, 1'b0, "R3");   // E into bit 15
    op(16'h3123, 1'b0, "R7");   // other opcode: no change
    op(16'hB080, 1'b1, "R7");   // other opcode with I set: no change

    // R8 R10 input path
    op(16'hF200, 1'b1, "R10");  // skip on input: empty, not taken
    give_char(8'h5A);
    give_char(8'h33);           // refused while full
    op(16'hF200, 1'b1, "R10");  // taken
    load_ac(16'hAB00);
    op(16'hF800, 1'b1, "R8");   // take char into low byte

    // R9 R10 output path
    op(16'hF100, 1'b1, "R10");  // output empty: taken
    load_ac(16'h12C3);
    op(16'hF400, 1'b1, "R9");
    idle(2);
    push("R9");                 // held while not accepted
    idle(1);
    load_ac(16'h0044);
    op(16'hF400, 1'b1, "R9");   // ignored while occupied
    op(16'hF100, 1'b1, "R10");  // occupied: not taken
    take_out();

    // R11 R12 interrupt
    load_pc(12'h123);
    fetch_phase = 1'b1;
    op(16'hF080, 1'b1, "R11");  // enable
    idle(3);
    fetch_req = 1'b1; @(negedge clk); fetch_req = 1'b0;
    check(irq_active == 1'b0, "R11", "irq_active in fetch", 32'(irq_active), 32'd0);
    fetch_phase = 1'b0;
    idle(2);
    fetch_phase = 1'b1;
    fetch_req = 1'b1; @(negedge clk); fetch_req = 1'b0;
    check(irq_active == 1'b1, "R12", "irq_active", 32'(irq_active), 32'd1);
    @(negedge clk);
    check(mem_wr == 1'b1, "R12", "mem_wr", 32'(mem_wr), 32'd1);
    check(mem_addr == 12'h000, "R12", "mem_addr", 32'(mem_addr), 32'd0);
    check(mem_data == 16'h0123, "R12", "mem_data", 32'(mem_data), 32'h123);
    @(negedge clk);
    check(pc_q == 12'h000, "R12", "pc mid", 32'(pc_q), 32'd0);
    check(sc_clr == 1'b1, "R12", "sc_clr", 32'(sc_clr), 32'd1);
    @(negedge clk);
    m_pc = 12'h001;
    check(pc_q == 12'h001, "R12", "pc entry", 32'(pc_q), 32'd1);
    check(irq_active == 1'b0, "R12", "irq_active end", 32'(irq_active), 32'd0);
    fetch_phase = 1'b0;
    idle(3);
    fetch_phase = 1'b1;
    fetch_req = 1'b1; @(negedge clk); fetch_req = 1'b0;
    check(irq_active == 1'b0, "R12", "disabled after cycle", 32'(irq_active), 32'd0);
    op(16'hF080, 1'b1, "R11");  // enable
    op(16'hF040, 1'b1, "R11");  // disable
    fetch_phase = 1'b0;
    idle(3);
    fetch_phase = 1'b1;
    fetch_req = 1'b1; @(negedge clk); fetch_req = 1'b0;
    check(irq_active == 1'b0, "R11", "disabled", 32'(irq_active), 32'd0);
    fetch_phase = 1'b0;

    // R6 halt
    op(16'h7001, 1'b0, "R6");
    idle(2);
    push("R6");
    idle(2);
    finish_run();
  end
endmodule